// File: doc/BRIEF.md
# Floating-Point Data Class Tester

This block sorts one IEEE 754 binary floating-point operand into one of twelve data classes. Each class pairs a sign with one of six categories: zero, normal, subnormal, infinity, quiet NaN or signaling NaN. It then reports whether a 12-bit selection mask contains that class. The operand arrives on a 128-bit bus. A 2-bit format code states whether the operand is a binary32, a binary64 or a binary128 value. Narrower values sit in the least significant bits of the bus.

The block produces two results. The class comes out as a one-hot 12-bit vector. The mask test comes out as a single hit bit, which serves as a 0/1 condition code. Both results are registered and appear one clock after a valid input.

Class numbering runs from the left. Class number n, counted from 0 to 11, is vector bit (11 − n). The same numbering applies to the selection mask, so a caller selects class n by setting bit (11 − n) of the mask.

Top module: `fp_class_test`

## Requirements
- R1: For every legal format, exactly one bit of `class_o` is set in the cycle where `valid_o` is high. Class number n maps to vector bit (11 − n).
- R2: A zero exponent field with a zero fraction is a zero. A positive zero is class 0 (`class_o` = 12'h800) and a negative zero is class 1 (12'h400).
- R3: An exponent field that is neither all zeros nor all ones gives a normal number. Normals are class 2 (12'h200) when positive and class 3 (12'h100) when negative.
- R4: A zero exponent field with a nonzero fraction gives a subnormal number, which is never reported as normal. Subnormals are class 4 (12'h080) when positive and class 5 (12'h040) when negative.
- R5: An all-ones exponent field with a zero fraction gives an infinity. Infinities are class 6 (12'h020) when positive and class 7 (12'h010) when negative.
- R6: An all-ones exponent field with a nonzero fraction gives a NaN. The NaN is quiet when the fraction MSB is 1: class 8 (12'h008) or class 9 (12'h004). It is signaling when the fraction MSB is 0: class 10 (12'h002) or class 11 (12'h001).
- R7: A set sign bit selects the class number one higher than the positive class, for every category including zeros and NaNs.
- R8: `match_o` is 1 exactly when `mask_i & class` is nonzero.
- R9: Format codes and field widths (sign, exponent, fraction) are as follows. Code 0 is binary32 (1/8/23). Code 1 is binary64 (1/11/52). Code 2 is binary128 (1/15/112). Fields are right-aligned on `operand_i`, and bus bits above the sign bit do not affect the result.
- R10: `valid_o` equals `valid_i` delayed by one clock. `class_o` and `match_o` reflect the operand, format and mask sampled on the edge where `valid_i` was high.
- R11: Format code 3 yields `class_o` = 0 and `match_o` = 0.
- R12: While `rst_ni` is low, `valid_o`, `class_o` and `match_o` are 0. After an edge with `valid_i` low, `class_o` and `match_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand, format and mask are valid |
| fmt_i | input | 2 | Format code: 0 binary32, 1 binary64, 2 binary128, 3 illegal |
| operand_i | input | 128 | Operand, right-aligned |
| mask_i | input | 12 | Class selection mask, class n at bit 11−n |
| valid_o | output | 1 | Result valid |
| class_o | output | 12 | One-hot class, class n at bit 11−n |
| match_o | output | 1 | Mask hit (condition code) |

## Verification
Several properties are checked on every cycle: the one-hot shape of the class vector, the match bit against the mask captured with the input, the one-cycle valid delay, the all-zero result for the illegal code, and holding of the result on idle edges. Only the bench's scenarios can show that each operand pattern lands in the right one of the twelve classes. Those scenarios also cover the subnormal/normal boundary and the quiet/signaling split on the fraction MSB. They also show that junk above a narrow format's sign bit has no effect.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  localparam int N_CLASS = 12;
  localparam int N_FMT   = 3;
  localparam int OP_W    = 128;

  typedef enum logic [1:0] {
    FMT_S   = 2'd0,
    FMT_D   = 2'd1,
    FMT_Q   = 2'd2,
    FMT_BAD = 2'd3
  } fmt_e;

  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_NORM = 3'd1,
    CL_SUB  = 3'd2,
    CL_INF  = 3'd3,
    CL_QNAN = 3'd4,
    CL_SNAN = 3'd5
  } cat_e;

  function automatic int exp_w(int f);
    case (f)
      0:       return 8;
      1:       return 11;
      default: return 15;
    endcase
  endfunction

  function automatic int frac_w(int f);
    case (f)
      0:       return 23;
      1:       return 52;
      default: return 112;
    endcase
  endfunction

  // class number = 2*category + sign, placed MSB-first
  function automatic logic [N_CLASS-1:0] class_vec(cat_e c, logic neg);
    int n;
    n = 2 * int'(c) + int'(neg);
    return N_CLASS'(1) << (N_CLASS - 1 - n);
  endfunction
endpackage

// File: rtl/fdc_classify.sv
module fdc_classify
  import fdc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int BUS_W  = 128
) (
  input  logic [BUS_W-1:0]   op_i,
  output logic [N_CLASS-1:0] class_o
);
  localparam int SIGN_POS = EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              neg;
  logic              exp_zero, exp_ones, frac_zero, frac_top;
  cat_e              cat;

  assign neg       = op_i[SIGN_POS];
  assign exp_f     = op_i[SIGN_POS-1:FRAC_W];
  assign frac_f    = op_i[FRAC_W-1:0];
  assign exp_zero  = (exp_f == '0);
  assign exp_ones  = &exp_f;
  assign frac_zero = (frac_f == '0);
  assign frac_top  = frac_f[FRAC_W-1];

  // common cases first; signaling NaN is what remains
  always_comb begin
    if (!exp_zero && !exp_ones)      cat = CL_NORM;
    else if (exp_zero && frac_zero)  cat = CL_ZERO;
    else if (exp_zero)               cat = CL_SUB;
    else if (frac_zero)              cat = CL_INF;
    else if (frac_top)               cat = CL_QNAN;
    else                             cat = CL_SNAN;
  end

  assign class_o = class_vec(cat, neg);
endmodule

// File: rtl/fdc_fmt_sel.sv
module fdc_fmt_sel
  import fdc_pkg::*;
(
  input  logic [N_FMT-1:0][N_CLASS-1:0] cand_i,
  input  logic [1:0]                    fmt_i,
  output logic [N_CLASS-1:0]            class_o
);
  always_comb begin
    class_o = '0;
    for (int f = 0; f < N_FMT; f++) begin
      if (int'(fmt_i) == f) class_o = cand_i[f];
    end
  end
endmodule

// File: rtl/fdc_mask_hit.sv
module fdc_mask_hit
  import fdc_pkg::*;
(
  input  logic [N_CLASS-1:0] class_i,
  input  logic [N_CLASS-1:0] mask_i,
  output logic               hit_o
);
  assign hit_o = |(class_i & mask_i);
endmodule

// File: rtl/fp_class_test.sv
module fp_class_test
  import fdc_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [1:0]          fmt_i,
  input  logic [OP_W-1:0]     operand_i,
  input  logic [N_CLASS-1:0]  mask_i,
  output logic                valid_o,
  output logic [N_CLASS-1:0]  class_o,
  output logic                match_o
);
  logic [N_FMT-1:0][N_CLASS-1:0] cand;
  logic [N_CLASS-1:0]            class_d, class_q;
  logic                          hit_d, hit_q, valid_q;

  for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
    fdc_classify #(
      .EXP_W (exp_w(g)),
      .FRAC_W(frac_w(g)),
      .BUS_W (OP_W)
    ) u_cls (
      .op_i   (operand_i),
      .class_o(cand[g])
    );
  end

  fdc_fmt_sel u_sel (
    .cand_i (cand),
    .fmt_i  (fmt_i),
    .class_o(class_d)
  );

  fdc_mask_hit u_hit (
    .class_i(class_d),
    .mask_i (mask_i),
    .hit_o  (hit_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      class_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        class_q <= class_d;
        hit_q   <= hit_d;
      end
    end
  end

  assign valid_o = valid_q;
  assign class_o = class_q;
  assign match_o = hit_q;
endmodule

// File: rtl/fp_class_test_chk.sv
module fp_class_test_chk
  import fdc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [1:0]         fmt_i,
  input logic [N_CLASS-1:0] mask_i,
  input logic               valid_o,
  input logic [N_CLASS-1:0] class_o,
  input logic               match_o
);
  AST_CLASS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(fmt_i) != FMT_BAD) |-> $countones(class_o) == 1); // R1

  AST_MATCH_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (match_o == |(class_o & $past(mask_i)))); // R8

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i)); // R10

  AST_ILLEGAL_FMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(fmt_i) == FMT_BAD) |-> (class_o == '0 && !match_o)); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(class_o) && $stable(match_o))); // R12
endmodule

bind fp_class_test fp_class_test_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .fmt_i  (fmt_i),
  .mask_i (mask_i),
  .valid_o(valid_o),
  .class_o(class_o),
  .match_o(match_o)
);

// File: tb/fp_class_test_tb.sv
module fp_class_test_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   fmt_i = 2'd0;
  logic [127:0] operand_i = '0;
  logic [11:0]  mask_i = '0;
  logic         valid_o;
  logic [11:0]  class_o;
  logic         match_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i; // 125 MHz

  fp_class_test u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .fmt_i(fmt_i),
    .operand_i(operand_i), .mask_i(mask_i),
    .valid_o(valid_o), .class_o(class_o), .match_o(match_o)
  );

  function automatic int ew_of(int f);
    return (f == 0) ? 8 : (f == 1) ? 11 : 15;
  endfunction
  function automatic int fw_of(int f);
    return (f == 0) ? 23 : (f == 1) ? 52 : 112;
  endfunction

  // cat: 0 zero,1 normal,2 subnormal,3 inf,4 qnan,5 snan
  function automatic logic [127:0] build(int f, int cat, int sgn, int v);
    int ew = ew_of(f);
    int fw = fw_of(f);
    logic [127:0] emax, fmask, fmsb, ex, fr, op, junk, low;
    emax  = (128'd1 << ew) - 128'd1;
    fmask = (128'd1 << fw) - 128'd1;
    fmsb  = 128'd1 << (fw - 1);
    ex = '0; fr = '0;
    case (cat)
      1: begin
        ex = (v == 0) ? 128'd1 : (v == 1) ? (emax >> 1) : (emax - 128'd1);
        fr = (v == 0) ? 128'd0 : (v == 1) ? 128'd1 : fmask;
      end
      2: fr = (v == 0) ? 128'd1 : (v == 1) ? fmsb : fmask;
      3: ex = emax;
      4: begin
        ex = emax;
        fr = fmsb | ((v == 0) ? 128'd0 : (v == 1) ? 128'd1 : fmask);
      end
      5: begin
        ex = emax;
        fr = (v == 0) ? 128'd1 : (v == 1) ? (fmsb >> 1) : (fmask >> 1);
      end
      default: ;
    endcase
    op = (128'(sgn) << (ew + fw)) | (ex << fw) | fr;
    if (f < 2) begin
      junk = (v == 0) ? 128'd0 : (v == 1) ? ~128'd0 : {4{32'hA5C3_3C5A}};
      low  = (128'd1 << (ew + fw + 1)) - 128'd1;
      op   = op | (junk & ~low);
    end
    return op;
  endfunction

  task automatic check12(string req, logic [11:0] act, logic [11:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %03h expected %03h", req, act, exp);
    end
  endtask

  task automatic check1(string req, logic act, logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  function automatic string cat_req(int cat);
    case (cat)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(logic [1:0] f, logic [127:0] op, logic [11:0] m);
    @(negedge clk_i);
    fmt_i = f; operand_i = op; mask_i = m; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    logic [11:0] exp_cls, m;
    repeat (3) @(negedge clk_i);
    check1("R12 reset valid", valid_o, 1'b0);
    check12("R12 reset class", class_o, 12'h000);
    check1("R12 reset match", match_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check1("R10 idle valid", valid_o, 1'b0);

    for (int f = 0; f < 3; f++) begin
      for (int cat = 0; cat < 6; cat++) begin
        for (int sgn = 0; sgn < 2; sgn++) begin
          for (int v = 0; v < 3; v++) begin
            exp_cls = 12'd1 << (11 - (2 * cat + sgn));
            for (int mi = 0; mi < 14; mi++) begin
              m = (mi < 12) ? (12'd1 << mi) : (mi == 12) ? 12'h000 : 12'hFFF;
              apply(2'(f), build(f, cat, sgn, v), m);
              check1("R10 valid", valid_o, 1'b1);
              check12((sgn != 0) ? "R7" : ((f < 2 && v != 0) ? "R9" : cat_req(cat)),
                      class_o, exp_cls);
              check1("R8 match", match_o, |(m & exp_cls));
            end
          end
        end
      end
    end

    // R1: single set bit at position 11-n for class number n
    apply(2'd2, build(2, 2, 1, 1), 12'h000);
    check1("R1 onehot", ($countones(class_o) == 1) && class_o[11 - 5], 1'b1);

    // R11 illegal format code 3
    apply(2'd3, build(0, 1, 0, 0), 12'hFFF);
    check12("R11 illegal class", class_o, 12'h000);
    check1("R11 illegal match", match_o, 1'b0);
    check1("R10 illegal valid", valid_o, 1'b1);

    // R12 hold: load known result, then change inputs with valid low
    apply(2'd1, build(1, 3, 1, 0), 12'h010);
    @(negedge clk_i);
    fmt_i = 2'd0; operand_i = build(0, 0, 0, 0); mask_i = 12'h000;
    @(negedge clk_i);
    check1("R12 hold valid", valid_o, 1'b0);
    check12("R12 hold class", class_o, 12'h010);
    check1("R12 hold match", match_o, 1'b1);

    // R9: binary32 inf with garbage that would make a binary64 normal
    apply(2'd0, {64'h4000_0000_0000_0000, 32'h1234_5678, 32'h7F80_0000}, 12'h020);
    check12("R9 upper ignored", class_o, 12'h020);
    check1("R9 upper match", match_o, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule